// File: doc/BRIEF.md
# Root Hub Port Status Controller

This block holds the status and the status-change state of one downstream port of a USB host root hub. Software reaches it through a plain 32-bit register: a write carries control requests in its lower half and write-1-to-clear acknowledgements in its upper half, and the read value shows the live port state below bit 16 and sticky change flags above it. Connect and over-current inputs arrive from the port logic. Two drive outputs ask the line logic to signal a port reset or a resume.

Two timed sequences run inside the block, driven by one down-counter. A port reset drives for 10 ms. A resume drives for 20 ms, then keeps the drive low for a short end-of-packet gap, then waits a 3 ms resynchronisation delay. A parameter gives the clock cycles per millisecond, so a bench can shorten these intervals. A write is never applied while a bus transaction is active. It waits in a one-entry holding register, and later writes merge into it, until the transaction-busy input drops.

Top module: `hub_port_status`

## Requirements
- R1: Read layout: bit 0 connected, bit 1 enabled, bit 2 suspended, bit 3 over-current indicator, bit 4 reset in progress; bit 17 enable-change, bit 18 resume-complete, bit 19 over-current-change, bit 20 reset-complete; all other bits (31:21, 16, 15:5) read as zero.
- R2: Write control bits are bit 4 reset, bit 0 disable, bit 1 enable, bit 2 suspend and bit 3 resume, in that priority when several are set. Enable takes effect only if the port is connected and over-current is clear. Suspend takes effect only on an enabled port. Disable clears both enabled and suspended.
- R3: A reset request on a connected port raises `reset_drive` for exactly 10*CYC_PER_MS cycles, with bit 4 set and bit 1 clear meanwhile. When the drive ends, bit 20 sets and bit 1 takes the connect state. A reset request on a disconnected port does nothing.
- R4: In the cycle that bit 20 sets, bit 18 is cleared.
- R5: Each change flag (bits 20..17) clears when a write carries 1 in its position. A 0 there leaves the flag as it was. If a set event and a clear arrive in the same cycle, the flag stays set.
- R6: Bit 19 sets whenever the over-current input changes, on a rise and on a fall.
- R7: On an enabled port, an over-current rise or a disconnect clears enabled and suspended and sets bit 17. A software disable does not set bit 17.
- R8: A resume request on a suspended port raises `resume_drive` for 20*CYC_PER_MS cycles. The drive then stays low for EOP_CYC cycles and then for 3*CYC_PER_MS more cycles. After that, bit 2 clears and bit 18 sets. Bit 2 stays set during the sequence.
- R9: A write is captured at its clock edge and applied at the first later edge at which `xact_busy` is low. It has no effect while `xact_busy` stays high.
- R10: A write that arrives while an earlier write is still held merges with it. The clear bits are ORed. A non-empty control request in the later write replaces the held one; an empty one keeps it.
- R11: After reset the read value is zero and both drive outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Write data: control requests and clear bits |
| rdata | output | 32 | Status (low half) and change flags (high half) |
| port_conn | input | 1 | Device connected on the port |
| port_ovc | input | 1 | Over-current indication for the port |
| xact_busy | input | 1 | A bus transaction is in progress |
| reset_drive | output | 1 | Request to signal port reset on the line |
| resume_drive | output | 1 | Request to signal resume on the line |

## Verification
The bench counts the exact length of the reset drive and the resume drive, and the length of the gap before resume completes. An off-by-one counter load or a missing end-of-packet phase would show up as a wrong count. It checks that reset completion wipes a pending resume-complete flag, and that writes held by a busy transaction stay invisible until release. A merge that dropped the earlier clear bits, or let an empty later request override a held one, would leave a flag set or the port disabled. It also checks that a software disable raises no enable-change flag, that a reset request on an empty port is ignored, and that set reserved write bits change nothing.

// File: rtl/hub_port_pkg.sv
// Package: shared bit positions, request and sequencer encodings for the
// root hub port status block. Assumes a 32-bit register view.
package hub_port_pkg;

    localparam int ST_CONN = 0;
    localparam int ST_EN   = 1;
    localparam int ST_SUSP = 2;
    localparam int ST_OVC  = 3;
    localparam int ST_RST  = 4;
    localparam int CF_EN   = 17;
    localparam int CF_SUSP = 18;
    localparam int CF_OVC  = 19;
    localparam int CF_RST  = 20;

    typedef enum logic [2:0] {
        REQ_NONE, REQ_DISABLE, REQ_ENABLE, REQ_SUSPEND, REQ_RESUME, REQ_RESET
    } port_req_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_RESET, SQ_RDRIVE, SQ_REOP, SQ_RSYNC
    } seq_state_e;

    // Pick one request out of the control bits; reset has highest priority.
    function automatic port_req_e decode_req(input logic [4:0] ctl);
        if (ctl[4])      return REQ_RESET;
        else if (ctl[0]) return REQ_DISABLE;
        else if (ctl[1]) return REQ_ENABLE;
        else if (ctl[2]) return REQ_SUSPEND;
        else if (ctl[3]) return REQ_RESUME;
        else             return REQ_NONE;
    endfunction

endpackage

// File: rtl/hub_port_defer.sv
// Module: one-entry holding register for software writes. Every write is
// captured; it is released (apply) on the first cycle the bus is idle.
// Writes that arrive while one is held merge: clear bits OR, and a
// non-empty later request replaces the held one.
module hub_port_defer
    import hub_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic [31:0] wdata,
    input  logic      xact_busy,
    output logic      apply,
    output logic [3:0] apply_clr,
    output port_req_e apply_req
);

    logic      pend;
    logic [3:0] pend_clr;
    port_req_e pend_req;
    port_req_e new_req;
    logic      unused_wbits;

    assign new_req      = decode_req(wdata[4:0]);
    assign unused_wbits = ^{wdata[31:21], wdata[16:5]};
    assign apply        = pend && !xact_busy;
    assign apply_clr    = pend_clr;
    assign apply_req    = pend_req;

    // Capture, merge or release the held write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_clr <= '0;
            pend_req <= REQ_NONE;
        end else if (wr_en) begin
            pend <= 1'b1;
            if (apply || !pend) begin
                pend_clr <= wdata[CF_RST:CF_EN];
                pend_req <= new_req;
            end else begin
                pend_clr <= pend_clr | wdata[CF_RST:CF_EN];
                if (new_req != REQ_NONE) pend_req <= new_req;
            end
        end else if (apply) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/hub_port_seq.sv
// Module: reset / resume sequencer with one shared down-counter.
// Reset: RST_CYC cycles of drive. Resume: DRV_CYC drive, EOP_CYC low,
// SYNC_CYC wait. Assumes every phase length is at least 1 and that the
// caller never starts a reset while one is running.
module hub_port_seq
    import hub_port_pkg::*;
#(
    parameter int RST_CYC  = 480000,
    parameter int DRV_CYC  = 960000,
    parameter int EOP_CYC  = 64,
    parameter int SYNC_CYC = 144000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_reset,
    input  logic start_resume,
    input  logic abort,
    output logic drive_reset,
    output logic drive_resume,
    output logic reset_done,
    output logic resume_done,
    output logic seq_idle
);

    localparam int MAXC1 = (RST_CYC > DRV_CYC) ? RST_CYC : DRV_CYC;
    localparam int MAXC2 = (EOP_CYC > SYNC_CYC) ? EOP_CYC : SYNC_CYC;
    localparam int MAXC  = (MAXC1 > MAXC2) ? MAXC1 : MAXC2;
    localparam int CW    = $clog2(MAXC + 1);

    seq_state_e    st;
    logic [CW-1:0] cnt;
    logic          cnt_zero;

    assign cnt_zero     = (cnt == '0);
    assign drive_reset  = (st == SQ_RESET);
    assign drive_resume = (st == SQ_RDRIVE);
    assign reset_done   = (st == SQ_RESET) && cnt_zero;
    assign resume_done  = (st == SQ_RSYNC) && cnt_zero && !abort;
    assign seq_idle     = (st == SQ_IDLE);

    // Phase state and counter; a reset start overrides any resume phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else if (start_reset) begin
            st  <= SQ_RESET;
            cnt <= CW'(RST_CYC - 1);
        end else if (abort && st != SQ_RESET && st != SQ_IDLE) begin
            st  <= SQ_IDLE;
        end else begin
            case (st)
                SQ_IDLE: if (start_resume) begin
                    st  <= SQ_RDRIVE;
                    cnt <= CW'(DRV_CYC - 1);
                end
                SQ_RESET: if (cnt_zero) st <= SQ_IDLE;
                          else cnt <= cnt - 1'b1;
                SQ_RDRIVE: if (cnt_zero) begin
                    st  <= SQ_REOP;
                    cnt <= CW'(EOP_CYC - 1);
                end else cnt <= cnt - 1'b1;
                SQ_REOP: if (cnt_zero) begin
                    st  <= SQ_RSYNC;
                    cnt <= CW'(SYNC_CYC - 1);
                end else cnt <= cnt - 1'b1;
                SQ_RSYNC: if (cnt_zero) st <= SQ_IDLE;
                          else cnt <= cnt - 1'b1;
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hub_port_status.sv
// Module: status and change-flag register for one root hub port.
// Writes pass through a deferral stage; timed sequences come from the
// sequencer. Hardware set beats software clear on a change flag.
// Assumes port_conn and port_ovc are already synchronised to clk.
module hub_port_status
    import hub_port_pkg::*;
#(
    parameter int CYC_PER_MS = 48000,
    parameter int EOP_CYC    = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        port_conn,
    input  logic        port_ovc,
    input  logic        xact_busy,
    output logic        reset_drive,
    output logic        resume_drive
);

    localparam int RST_CYC  = 10 * CYC_PER_MS;
    localparam int DRV_CYC  = 20 * CYC_PER_MS;
    localparam int SYNC_CYC = 3 * CYC_PER_MS;

    logic      wr_apply;
    logic [3:0] wr_clr;
    logic [3:0] clr_now;
    port_req_e wr_req;
    logic      conn_q, ovc_q, en_q, susp_q;
    logic      chg_en, chg_susp, chg_ovc, chg_rst;
    logic      start_reset, start_resume, seq_abort;
    logic      reset_done, resume_done, seq_idle;
    logic      dis_evt, sw_disable;

    hub_port_defer u_defer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .xact_busy (xact_busy),
        .apply     (wr_apply),
        .apply_clr (wr_clr),
        .apply_req (wr_req)
    );

    hub_port_seq #(
        .RST_CYC  (RST_CYC),
        .DRV_CYC  (DRV_CYC),
        .EOP_CYC  (EOP_CYC),
        .SYNC_CYC (SYNC_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_reset  (start_reset),
        .start_resume (start_resume),
        .abort        (seq_abort),
        .drive_reset  (reset_drive),
        .drive_resume (resume_drive),
        .reset_done   (reset_done),
        .resume_done  (resume_done),
        .seq_idle     (seq_idle)
    );

    assign clr_now      = wr_apply ? wr_clr : 4'b0000;
    assign dis_evt      = en_q && ((conn_q && !port_conn) || (!ovc_q && port_ovc));
    assign sw_disable   = wr_apply && (wr_req == REQ_DISABLE);
    assign start_reset  = wr_apply && (wr_req == REQ_RESET) && conn_q && !reset_drive;
    assign start_resume = wr_apply && (wr_req == REQ_RESUME) && susp_q && seq_idle;
    assign seq_abort    = dis_evt || sw_disable;

    // Sample the port inputs for status and edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_q <= 1'b0;
            ovc_q  <= 1'b0;
        end else begin
            conn_q <= port_conn;
            ovc_q  <= port_ovc;
        end
    end

    // Enabled and suspended state, in event priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            if (reset_done)                     en_q <= port_conn;
            else if (start_reset)               en_q <= 1'b0;
            else if (dis_evt || sw_disable)     en_q <= 1'b0;
            else if (wr_apply && wr_req == REQ_ENABLE && conn_q && !ovc_q)
                                                en_q <= 1'b1;

            if (reset_done || start_reset || dis_evt || sw_disable || resume_done)
                susp_q <= 1'b0;
            else if (wr_apply && wr_req == REQ_SUSPEND && en_q && seq_idle)
                susp_q <= 1'b1;
        end
    end

    // Sticky change flags: set events win over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_en   <= 1'b0;
            chg_susp <= 1'b0;
            chg_ovc  <= 1'b0;
            chg_rst  <= 1'b0;
        end else begin
            chg_en  <= dis_evt | (chg_en & ~clr_now[0]);
            chg_ovc <= (ovc_q != port_ovc) | (chg_ovc & ~clr_now[2]);
            chg_rst <= reset_done | (chg_rst & ~clr_now[3]);
            if (reset_done) chg_susp <= 1'b0;
            else            chg_susp <= resume_done | (chg_susp & ~clr_now[1]);
        end
    end

    // Assemble the read view; unassigned positions read zero.
    always_comb begin
        rdata          = '0;
        rdata[ST_CONN] = conn_q;
        rdata[ST_EN]   = en_q;
        rdata[ST_SUSP] = susp_q;
        rdata[ST_OVC]  = ovc_q;
        rdata[ST_RST]  = reset_drive;
        rdata[CF_EN]   = chg_en;
        rdata[CF_SUSP] = chg_susp;
        rdata[CF_OVC]  = chg_ovc;
        rdata[CF_RST]  = chg_rst;
    end

endmodule

// File: rtl/hub_port_status_chk.sv
// Module: protocol checker for hub_port_status, attached by bind.
// Assumes RST_CYC equals the reset drive length of the bound instance.
module hub_port_status_chk #(
    parameter int RST_CYC = 480000
) (
    input logic clk,
    input logic rst_n,
    input logic port_conn,
    input logic port_ovc,
    input logic xact_busy,
    input logic wr_apply,
    input logic reset_drive,
    input logic resume_drive,
    input logic s_conn,
    input logic s_en,
    input logic s_ovc,
    input logic c_en,
    input logic c_susp,
    input logic c_ovc,
    input logic c_rst
);

    int unsigned rst_len;

    // Length of the current reset drive, in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          rst_len <= 0;
        else if (reset_drive) rst_len <= rst_len + 1;
        else                 rst_len <= 0;
    end

    p_apply_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_apply |-> !xact_busy);

    p_one_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_drive && resume_drive));

    p_rst_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_drive) |-> c_rst);

    p_rst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_drive) |-> (rst_len == RST_CYC));

    p_susp_wipe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_rst) |-> !c_susp);

    p_ovc_chg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_ovc != s_ovc) |=> c_ovc);

    p_disc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_en && s_conn && !port_conn) |=> (c_en && !s_en));

endmodule

bind hub_port_status hub_port_status_chk #(.RST_CYC(10 * CYC_PER_MS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_conn    (port_conn),
    .port_ovc     (port_ovc),
    .xact_busy    (xact_busy),
    .wr_apply     (wr_apply),
    .reset_drive  (reset_drive),
    .resume_drive (resume_drive),
    .s_conn       (rdata[0]),
    .s_en         (rdata[1]),
    .s_ovc        (rdata[3]),
    .c_en         (rdata[17]),
    .c_susp       (rdata[18]),
    .c_ovc        (rdata[19]),
    .c_rst        (rdata[20])
);

// File: tb/tb_hub_port_status.sv
// Bench: vector table walked by one loop, then directed sequence tests.
module tb_hub_port_status;

    localparam int CPM = 4;
    localparam int EOP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        port_conn = 1'b0;
    logic        port_ovc = 1'b0;
    logic        xact_busy = 1'b0;
    logic        reset_drive, resume_drive;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    hub_port_status #(.CYC_PER_MS(CPM), .EOP_CYC(EOP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .port_conn(port_conn), .port_ovc(port_ovc), .xact_busy(xact_busy),
        .reset_drive(reset_drive), .resume_drive(resume_drive)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] wd;
        logic        conn;
        logic        ovc;
        logic [3:0]  req;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 4'd1,  32'h0000_0001},
        '{1'b1, 32'h0000_0002, 1'b1, 1'b0, 4'd2,  32'h0000_0003},
        '{1'b1, 32'h0000_0004, 1'b1, 1'b0, 4'd2,  32'h0000_0007},
        '{1'b0, 32'h0000_0000, 1'b1, 1'b1, 4'd7,  32'h000A_0009},
        '{1'b1, 32'h0000_0002, 1'b1, 1'b1, 4'd2,  32'h000A_0009},
        '{1'b1, 32'h0008_0000, 1'b1, 1'b1, 4'd5,  32'h0002_0009},
        '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 4'd6,  32'h000A_0001},
        '{1'b1, 32'h000A_0000, 1'b1, 1'b0, 4'd5,  32'h0000_0001},
        '{1'b1, 32'h0000_0002, 1'b1, 1'b0, 4'd2,  32'h0000_0003},
        '{1'b0, 32'h0000_0000, 1'b0, 1'b0, 4'd7,  32'h0002_0000},
        '{1'b1, 32'h0000_0000, 1'b0, 1'b0, 4'd5,  32'h0002_0000},
        '{1'b1, 32'h0000_0002, 1'b0, 1'b0, 4'd2,  32'h0002_0000},
        '{1'b1, 32'h0002_0000, 1'b1, 1'b0, 4'd5,  32'h0000_0001},
        '{1'b1, 32'hFFE0_0002, 1'b1, 1'b0, 4'd1,  32'h0000_0003},
        '{1'b1, 32'h0000_0001, 1'b1, 1'b0, 4'd7,  32'h0000_0001}
    };

    function automatic string req_tag(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd5: return "R5";
            4'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One write strobe; returns at the negedge after the capture edge.
    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wdata = d;
        tick();
        wr_en = 1'b0;
        wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        // R11: state right after reset
        check("R11", rdata, 32'h0);
        check("R11", {30'b0, reset_drive, resume_drive}, 32'h0);

        // Table walk: each vector spans two clock edges
        for (int i = 0; i < NV; i++) begin
            port_conn = VEC[i].conn;
            port_ovc  = VEC[i].ovc;
            wr_en     = VEC[i].wr;
            wdata     = VEC[i].wd;
            tick();
            wr_en = 1'b0;
            wdata = '0;
            tick();
            check(req_tag(VEC[i].req), rdata, VEC[i].exp);
        end

        // R6: over-current change flag on a port that is not enabled
        port_ovc = 1'b1; tick(); tick();
        check("R6", rdata, 32'h0008_0009);
        port_ovc = 1'b0; tick(); tick();
        check("R6", rdata, 32'h0008_0001);

        // R9: held while busy; R10: merge keeps request and clear bits
        xact_busy = 1'b1;
        wr(32'h0000_0002);
        wr(32'h0008_0000);
        repeat (4) tick();
        check("R9", rdata, 32'h0008_0001);
        xact_busy = 1'b0;
        tick();
        check("R10", rdata, 32'h0000_0003);

        // R10: later non-empty request replaces held one; R7: no flag on software disable
        xact_busy = 1'b1;
        wr(32'h0000_0004);
        wr(32'h0000_0001);
        xact_busy = 1'b0;
        tick();
        check("R10", rdata, 32'h0000_0001);

        // R9: one edge after capture when idle
        wr(32'h0000_0002);
        check("R9", rdata, 32'h0000_0001);
        tick();
        check("R9", rdata, 32'h0000_0003);

        // R8: resume sequence timing
        wr(32'h0000_0004);
        tick();
        check("R2", rdata, 32'h0000_0007);
        wr(32'h0000_0008);
        cnt = 0;
        for (int k = 0; k < 1000; k++) begin
            tick();
            if (k == 0) check("R8", {31'b0, rdata[2]}, 32'h1);
            if (!resume_drive) break;
            cnt++;
        end
        check("R8", cnt, 20 * CPM);
        cnt = 1;
        for (int k = 0; k < 1000; k++) begin
            if (rdata[18]) break;
            tick();
            if (!rdata[18]) cnt++;
        end
        check("R8", cnt, EOP + 3 * CPM);
        check("R8", rdata, 32'h0004_0003);

        // R3 / R4: port reset sequence
        wr(32'h0000_0010);
        tick();
        check("R3", rdata, 32'h0004_0011);
        cnt = 1;
        for (int k = 0; k < 1000; k++) begin
            tick();
            if (!reset_drive) break;
            cnt++;
        end
        check("R3", cnt, 10 * CPM);
        check("R4", rdata, 32'h0010_0003);

        // R5: clear reset-complete flag
        wr(32'h0010_0000);
        tick();
        check("R5", rdata, 32'h0000_0003);

        // R3: reset on a disconnected port is ignored
        port_conn = 1'b0; tick(); tick();
        check("R7", rdata, 32'h0002_0000);
        wr(32'h0002_0010);
        tick();
        check("R3", rdata, 32'h0000_0000);
        check("R3", {31'b0, reset_drive}, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule